// File: doc/BRIEF.md
# Multi-Level Trace Trigger Sequencer

This block watches a bus sample (address, data and status) on every clock and steps through a fixed number of trigger levels. Each level has its own qualifier. The qualifier checks that the address lies in an inclusive window and tests the data against a masked value: equal to it, unsigned less than it, or inside a masked window. A masked status match is always required. The address and data terms are joined by AND or by OR, chosen per level.

A level is tested only while the sequencer sits on it. A qualifying valid sample moves the sequencer to the next level. When the last level has matched, a 20-bit counter counts further valid samples up to a programmed delay. The block then emits a one-cycle trigger pulse and, when enabled, a break request for run control. It stays triggered until it is re-armed.

Trace capture logic uses the trigger to freeze a circular trace buffer. The break output acts as a hardware breakpoint. All configuration inputs are assumed to be held static between arm pulses.

Top module: `trig_seq_top`

## Requirements
- R1: While reset is active and in the cycle after it is released, `cur_level` is 0 and `trig_pulse`, `brk_req` and `triggered` are all 0.
- R2: The address term of a level is true when `cfg_addr_lo <= smp_addr <= cfg_addr_hi`, with both bounds inclusive.
- R3: The data term applies the level's mask to both the sample and the constants. The op code selects the test: 0 is equal, 1 is unsigned less-than `cfg_data_val`, and 2 is the inclusive window from `cfg_data_val` to `cfg_data_hi`. Op code 3 never matches.
- R4: A level qualifies only if `(smp_stat & mask) == (cfg_stat_val & mask)`, whatever the other terms give.
- R5: When a level's `cfg_and_sel` bit is 1, the address and data terms are joined by AND. When it is 0, they are joined by OR.
- R6: Only the qualifier of the current level is tested. `cur_level` rises by at most 1 per clock and only on a cycle with `smp_valid` high, so one sample never clears two levels. A sample with `smp_valid` low has no effect.
- R7: Once the last level matches, `cur_level` reads NUM_LEVELS. The trigger fires on the `cfg_delay`-th later valid sample, or on the matching sample itself if `cfg_delay` is 0. Delays up to 2^20-1, for example 100000, are counted exactly.
- R8: `trig_pulse` is high for exactly one cycle, in the cycle after the edge that captured the firing sample. `triggered` then stays high, and no further pulse occurs until `arm`.
- R9: `brk_req` pulses together with `trig_pulse` only when `cfg_break_en` is 1. Otherwise it stays 0.
- R10: `arm` returns the sequencer to level 0 with the counter cleared and `triggered` low. It takes priority over any sample presented in the same cycle, including one that would fire the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Restart the sequence at level 0 |
| smp_valid | input | 1 | Bus sample is valid this cycle |
| smp_addr | input | ADDR_W | Sampled address |
| smp_data | input | DATA_W | Sampled data |
| smp_stat | input | STAT_W | Sampled status bits |
| cfg_addr_lo | input | NUM_LEVELS*ADDR_W | Per-level lower address bound |
| cfg_addr_hi | input | NUM_LEVELS*ADDR_W | Per-level upper address bound |
| cfg_data_val | input | NUM_LEVELS*DATA_W | Per-level data value / window low end |
| cfg_data_hi | input | NUM_LEVELS*DATA_W | Per-level data window high end |
| cfg_data_mask | input | NUM_LEVELS*DATA_W | Per-level data mask |
| cfg_data_op | input | NUM_LEVELS*2 | Per-level data op (0 eq, 1 lt, 2 window, 3 never) |
| cfg_stat_val | input | NUM_LEVELS*STAT_W | Per-level status value |
| cfg_stat_mask | input | NUM_LEVELS*STAT_W | Per-level status mask |
| cfg_and_sel | input | NUM_LEVELS | Per-level join: 1 AND, 0 OR |
| cfg_delay | input | CNT_W | Valid samples between last match and trigger |
| cfg_break_en | input | 1 | Route trigger to break request |
| trig_pulse | output | 1 | One-cycle trigger |
| brk_req | output | 1 | One-cycle break request |
| cur_level | output | clog2(NUM_LEVELS+1) | Current level; NUM_LEVELS once past the last level |
| triggered | output | 1 | Trigger has fired since the last arm |

## Verification
Two functions can land on the same cycle. The first is an arm pulse arriving together with a sample that would fire the trigger or advance a level. The bench provokes this while the delay counter is one sample short of firing, and expects level 0 with no pulse. The second is a single sample that satisfies the current level and the next one. The bench expects exactly one step per clock. A behavioural reference model is compared against `cur_level`, `trig_pulse`, `brk_req` and `triggered` on every clock, with directed checks at each boundary.

// File: rtl/trig_seq_pkg.sv
// Shared encodings for the trigger sequencer.
// Assumes: the data op field is 2 bits wide at every level.
package trig_seq_pkg;

    typedef enum logic [1:0] {
        DOP_EQ    = 2'd0,
        DOP_LT    = 2'd1,
        DOP_RANGE = 2'd2,
        DOP_NEVER = 2'd3
    } data_op_e;

    typedef enum logic [1:0] {
        PH_SEEK  = 2'd0,
        PH_COUNT = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

endpackage

// File: rtl/trig_level_match.sv
// Combinational qualifier for one trigger level.
// Tests an inclusive address window and a masked data compare (eq / lt / window / never).
// The address and data terms are joined by AND or OR; a masked status match is always required.
// Assumes: the sample and the configuration are stable within the cycle.
module trig_level_match
    import trig_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int STAT_W = 4
) (
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [STAT_W-1:0] smp_stat,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic [DATA_W-1:0] data_val,
    input  logic [DATA_W-1:0] data_hi,
    input  logic [DATA_W-1:0] data_mask,
    input  logic [1:0]        data_op,
    input  logic [STAT_W-1:0] stat_val,
    input  logic [STAT_W-1:0] stat_mask,
    input  logic              and_sel,
    output logic              hit
);

    logic [DATA_W-1:0] d_smp, d_lo, d_hi;
    logic              addr_ok, data_ok, stat_ok, join_ok;

    // Apply the data mask to the sample and both data constants.
    always_comb begin
        d_smp = smp_data & data_mask;
        d_lo  = data_val & data_mask;
        d_hi  = data_hi  & data_mask;
    end

    // Inclusive address window.
    always_comb begin
        addr_ok = (smp_addr >= addr_lo) && (smp_addr <= addr_hi);
    end

    // Data relation selected by the op code.
    always_comb begin
        unique case (data_op_e'(data_op))
            DOP_EQ:    data_ok = (d_smp == d_lo);
            DOP_LT:    data_ok = (d_smp <  d_lo);
            DOP_RANGE: data_ok = (d_smp >= d_lo) && (d_smp <= d_hi);
            default:   data_ok = 1'b0;
        endcase
    end

    // Status match, then the AND/OR join of the address and data terms.
    always_comb begin
        stat_ok = ((smp_stat ^ stat_val) & stat_mask) == '0;
        join_ok = and_sel ? (addr_ok && data_ok) : (addr_ok || data_ok);
        hit     = join_ok && stat_ok;
    end

endmodule

// File: rtl/trig_seq_ctrl.sv
// Level sequencer, post-match delay counter and trigger/break output registers.
// Advances at most one level per valid sample, counts valid samples after the last level,
// and fires a one-cycle trigger. Arm has priority over everything else.
// Assumes: cfg_delay and cfg_break_en are static between arm pulses; NUM_LEVELS >= 2.
module trig_seq_ctrl
    import trig_seq_pkg::*;
#(
    parameter int NUM_LEVELS = 3,
    parameter int CNT_W      = 20,
    parameter int LVL_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic                  smp_valid,
    input  logic [NUM_LEVELS-1:0] lvl_hit,
    input  logic [CNT_W-1:0]      cfg_delay,
    input  logic                  cfg_break_en,
    output logic                  trig_pulse,
    output logic                  brk_req,
    output logic [LVL_W-1:0]      level_out,
    output logic                  done
);

    localparam int               PAD_N    = 1 << LVL_W;
    localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(NUM_LEVELS - 1);
    localparam logic [LVL_W-1:0] LVL_PAST = LVL_W'(NUM_LEVELS);

    phase_e           phase_q;
    logic [LVL_W-1:0] level_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PAD_N-1:0] hit_pad;
    logic             cur_hit, last_hit, cnt_end, fire;

    // Select the current level's qualifier and decide whether this cycle fires.
    always_comb begin
        hit_pad  = PAD_N'(lvl_hit);
        cur_hit  = (phase_q == PH_SEEK) && smp_valid && hit_pad[level_q];
        last_hit = cur_hit && (level_q == LVL_LAST);
        cnt_end  = (phase_q == PH_COUNT) && smp_valid && ((cnt_q + 1'b1) == cfg_delay);
        fire     = !arm && ((last_hit && (cfg_delay == '0)) || cnt_end);
    end

    // Phase and level register: step on a qualifying sample, restart on arm.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            phase_q <= PH_SEEK;
            level_q <= '0;
        end else begin
            unique case (phase_q)
                PH_SEEK: begin
                    if (last_hit) begin
                        level_q <= LVL_PAST;
                        phase_q <= (cfg_delay == '0) ? PH_DONE : PH_COUNT;
                    end else if (cur_hit) begin
                        level_q <= level_q + 1'b1;
                    end
                end
                PH_COUNT: if (cnt_end) phase_q <= PH_DONE;
                default:  phase_q <= phase_q;
            endcase
        end
    end

    // Delay counter: counts valid samples while in the counting phase.
    always_ff @(posedge clk) begin
        if (!rst_n || arm || phase_q != PH_COUNT) begin
            cnt_q <= '0;
        end else if (smp_valid && !cnt_end) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered trigger and gated break pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_pulse <= 1'b0;
            brk_req    <= 1'b0;
        end else begin
            trig_pulse <= fire;
            brk_req    <= fire && cfg_break_en;
        end
    end

    assign level_out = level_q;
    assign done      = (phase_q == PH_DONE);

    // Marks cycles whose previous edge was already out of reset.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse); // R8
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> !trig_pulse); // R8
    AST_BRK_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> trig_pulse); // R9
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && level_out != $past(level_out) && !$past(arm))
            |-> (level_out == $past(level_out) + 1'b1)); // R6
    AST_STEP_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && level_out != $past(level_out) && !$past(arm)) |-> $past(smp_valid)); // R6
    AST_CNT_BELOW_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_COUNT) |-> (cnt_q < cfg_delay)); // R7

endmodule

// File: rtl/trig_seq_top.sv
// Top of the multi-level trace trigger sequencer.
// Builds one qualifier per level from flat per-level configuration vectors and feeds the sequencer.
// Assumes: level i uses slice i of each configuration vector; configuration is static between arms.
module trig_seq_top #(
    parameter int NUM_LEVELS = 3,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int STAT_W     = 4,
    parameter int CNT_W      = 20,
    localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         arm,
    input  logic                         smp_valid,
    input  logic [ADDR_W-1:0]            smp_addr,
    input  logic [DATA_W-1:0]            smp_data,
    input  logic [STAT_W-1:0]            smp_stat,
    input  logic [NUM_LEVELS*ADDR_W-1:0] cfg_addr_lo,
    input  logic [NUM_LEVELS*ADDR_W-1:0] cfg_addr_hi,
    input  logic [NUM_LEVELS*DATA_W-1:0] cfg_data_val,
    input  logic [NUM_LEVELS*DATA_W-1:0] cfg_data_hi,
    input  logic [NUM_LEVELS*DATA_W-1:0] cfg_data_mask,
    input  logic [NUM_LEVELS*2-1:0]      cfg_data_op,
    input  logic [NUM_LEVELS*STAT_W-1:0] cfg_stat_val,
    input  logic [NUM_LEVELS*STAT_W-1:0] cfg_stat_mask,
    input  logic [NUM_LEVELS-1:0]        cfg_and_sel,
    input  logic [CNT_W-1:0]             cfg_delay,
    input  logic                         cfg_break_en,
    output logic                         trig_pulse,
    output logic                         brk_req,
    output logic [LVL_W-1:0]             cur_level,
    output logic                         triggered
);

    logic [NUM_LEVELS-1:0] lvl_hit;

    // One qualifier per level, each on its own configuration slice.
    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
        trig_level_match #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .STAT_W (STAT_W)
        ) u_match (
            .smp_addr  (smp_addr),
            .smp_data  (smp_data),
            .smp_stat  (smp_stat),
            .addr_lo   (cfg_addr_lo  [lv*ADDR_W +: ADDR_W]),
            .addr_hi   (cfg_addr_hi  [lv*ADDR_W +: ADDR_W]),
            .data_val  (cfg_data_val [lv*DATA_W +: DATA_W]),
            .data_hi   (cfg_data_hi  [lv*DATA_W +: DATA_W]),
            .data_mask (cfg_data_mask[lv*DATA_W +: DATA_W]),
            .data_op   (cfg_data_op  [lv*2 +: 2]),
            .stat_val  (cfg_stat_val [lv*STAT_W +: STAT_W]),
            .stat_mask (cfg_stat_mask[lv*STAT_W +: STAT_W]),
            .and_sel   (cfg_and_sel[lv]),
            .hit       (lvl_hit[lv])
        );
    end

    trig_seq_ctrl #(
        .NUM_LEVELS (NUM_LEVELS),
        .CNT_W      (CNT_W),
        .LVL_W      (LVL_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm),
        .smp_valid    (smp_valid),
        .lvl_hit      (lvl_hit),
        .cfg_delay    (cfg_delay),
        .cfg_break_en (cfg_break_en),
        .trig_pulse   (trig_pulse),
        .brk_req      (brk_req),
        .level_out    (cur_level),
        .done         (triggered)
    );

endmodule

// File: tb/trig_seq_top_tb_top.sv
// Bench for trig_seq_top: a behavioural reference model compared on every clock,
// plus directed checks at each boundary named by the requirements.
module trig_seq_top_tb_top;

    localparam int NL = 3;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SW = 4;
    localparam int CW = 20;
    localparam int LW = $clog2(NL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic smp_valid = 1'b0;
    logic [AW-1:0] smp_addr = '0;
    logic [DW-1:0] smp_data = '0;
    logic [SW-1:0] smp_stat = '0;

    logic [AW-1:0] b_alo [NL];
    logic [AW-1:0] b_ahi [NL];
    logic [DW-1:0] b_dval[NL];
    logic [DW-1:0] b_dhi [NL];
    logic [DW-1:0] b_dmsk[NL];
    logic [1:0]    b_op  [NL];
    logic [SW-1:0] b_sval[NL];
    logic [SW-1:0] b_smsk[NL];
    logic          b_and [NL];
    logic [CW-1:0] cfg_delay = '0;
    logic          cfg_break_en = 1'b0;

    logic [NL*AW-1:0] cfg_addr_lo, cfg_addr_hi;
    logic [NL*DW-1:0] cfg_data_val, cfg_data_hi, cfg_data_mask;
    logic [NL*2-1:0]  cfg_data_op;
    logic [NL*SW-1:0] cfg_stat_val, cfg_stat_mask;
    logic [NL-1:0]    cfg_and_sel;

    logic          trig_pulse, brk_req, triggered;
    logic [LW-1:0] cur_level;

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            cfg_addr_lo  [i*AW +: AW] = b_alo[i];
            cfg_addr_hi  [i*AW +: AW] = b_ahi[i];
            cfg_data_val [i*DW +: DW] = b_dval[i];
            cfg_data_hi  [i*DW +: DW] = b_dhi[i];
            cfg_data_mask[i*DW +: DW] = b_dmsk[i];
            cfg_data_op  [i*2 +: 2]   = b_op[i];
            cfg_stat_val [i*SW +: SW] = b_sval[i];
            cfg_stat_mask[i*SW +: SW] = b_smsk[i];
            cfg_and_sel[i]            = b_and[i];
        end
    end

    trig_seq_top #(
        .NUM_LEVELS (NL), .ADDR_W (AW), .DATA_W (DW), .STAT_W (SW), .CNT_W (CW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .arm (arm), .smp_valid (smp_valid),
        .smp_addr (smp_addr), .smp_data (smp_data), .smp_stat (smp_stat),
        .cfg_addr_lo (cfg_addr_lo), .cfg_addr_hi (cfg_addr_hi),
        .cfg_data_val (cfg_data_val), .cfg_data_hi (cfg_data_hi),
        .cfg_data_mask (cfg_data_mask), .cfg_data_op (cfg_data_op),
        .cfg_stat_val (cfg_stat_val), .cfg_stat_mask (cfg_stat_mask),
        .cfg_and_sel (cfg_and_sel), .cfg_delay (cfg_delay),
        .cfg_break_en (cfg_break_en),
        .trig_pulse (trig_pulse), .brk_req (brk_req),
        .cur_level (cur_level), .triggered (triggered)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference qualifier from R2..R5.
    function automatic bit ref_hit(input int lv, input int a, input int d, input int s);
        int m, ds, lo, hi;
        bit aok, dok, sok;
        m   = int'(b_dmsk[lv]);
        ds  = d & m;
        lo  = int'(b_dval[lv]) & m;
        hi  = int'(b_dhi[lv]) & m;
        aok = (a >= int'(b_alo[lv])) && (a <= int'(b_ahi[lv]));
        case (b_op[lv])
            2'd0:    dok = (ds == lo);
            2'd1:    dok = (ds < lo);
            2'd2:    dok = (ds >= lo) && (ds <= hi);
            default: dok = 1'b0;
        endcase
        sok = ((s & int'(b_smsk[lv])) == (int'(b_sval[lv]) & int'(b_smsk[lv])));
        return (b_and[lv] ? (aok && dok) : (aok || dok)) && sok;
    endfunction

    // Reference model state: 0 seeking, 1 counting, 2 done.
    int m_phase = 0, m_level = 0, m_cnt = 0;
    bit m_trig = 0, m_brk = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_level = 0; m_cnt = 0; m_trig = 0; m_brk = 0;
        end else begin
            bit fire;
            fire = 0;
            if (arm) begin
                m_phase = 0; m_level = 0; m_cnt = 0;
            end else if (m_phase == 0) begin
                if (smp_valid && ref_hit(m_level, int'(smp_addr), int'(smp_data), int'(smp_stat))) begin
                    if (m_level == NL - 1) begin
                        m_level = NL;
                        m_cnt   = 0;
                        if (cfg_delay == 0) begin fire = 1; m_phase = 2; end
                        else m_phase = 1;
                    end else begin
                        m_level++;
                    end
                end
            end else if (m_phase == 1 && smp_valid) begin
                m_cnt++;
                if (m_cnt == int'(cfg_delay)) begin fire = 1; m_phase = 2; end
            end
            m_trig = fire;
            m_brk  = fire && cfg_break_en;
        end
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(cur_level),  m_level,          "R6 cur_level vs model");
            chk(int'(trig_pulse), int'(m_trig),     "R8 trig_pulse vs model");
            chk(int'(brk_req),    int'(m_brk),      "R9 brk_req vs model");
            chk(int'(triggered),  int'(m_phase == 2), "R8 triggered vs model");
        end
    end

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input bit v, input int a, input int d, input int s);
        smp_valid = v;
        smp_addr  = AW'(a);
        smp_data  = DW'(d);
        smp_stat  = SW'(s);
        @(negedge clk);
    endtask

    task automatic do_arm(input bit v, input int a, input int d, input int s);
        arm = 1'b1;
        step(v, a, d, s);
        arm = 1'b0;
    endtask

    task automatic pass_levels();
        step(1, 'h100, 'h55, 2);
        step(1, 'h200, 'h9999, 0);
        step(1, 'hF000, 'h10, 0);
    endtask

    initial begin
        // Level 0: addr window, data eq 0x55 masked to the low byte, AND, write bit (bit 1) required.
        b_alo[0] = 'h100;  b_ahi[0] = 'h1FF;  b_dval[0] = 'h55;   b_dhi[0] = 'h0;
        b_dmsk[0] = 'h00FF; b_op[0] = 2'd0;   b_sval[0] = 4'h2;   b_smsk[0] = 4'h2; b_and[0] = 1'b1;
        // Level 1: single address OR data below 0x1000; status ignored.
        b_alo[1] = 'h200;  b_ahi[1] = 'h200;  b_dval[1] = 'h1000; b_dhi[1] = 'h0;
        b_dmsk[1] = 'hFFFF; b_op[1] = 2'd1;   b_sval[1] = 4'h0;   b_smsk[1] = 4'h0; b_and[1] = 1'b0;
        // Level 2: high address window AND low byte of data in [0x10,0x20].
        b_alo[2] = 'hF000; b_ahi[2] = 'hFFFF; b_dval[2] = 'h10;   b_dhi[2] = 'h20;
        b_dmsk[2] = 'h00FF; b_op[2] = 2'd2;   b_sval[2] = 4'h0;   b_smsk[2] = 4'h0; b_and[2] = 1'b1;
        cfg_delay = '0;
        cfg_break_en = 1'b1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(int'(cur_level), 0, "R1 reset level");
        chk(int'(trig_pulse), 0, "R1 reset trig");
        chk(int'(brk_req), 0, "R1 reset brk");
        chk(int'(triggered), 0, "R1 reset triggered");

        // Scenario A: qualifier terms and an immediate trigger.
        step(1, 'h0FF, 'h55, 2);   chk(int'(cur_level), 0, "R2 addr below window");
        step(1, 'h100, 'h55, 0);   chk(int'(cur_level), 0, "R4 status mismatch");
        step(0, 'h100, 'h55, 2);   chk(int'(cur_level), 0, "R6 invalid sample ignored");
        step(1, 'h1FF, 'h1255, 2); chk(int'(cur_level), 1, "R2 upper bound inclusive, R3 masked eq");
        step(1, 'h300, 'h2000, 0); chk(int'(cur_level), 1, "R5 OR both false");
        step(1, 'h300, 'h0FFF, 0); chk(int'(cur_level), 2, "R3 less-than, R5 OR data only");
        step(1, 'hF000, 'h21, 0);  chk(int'(cur_level), 2, "R3 above data window");
        step(1, 'hEFFF, 'h15, 0);  chk(int'(cur_level), 2, "R5 AND address miss");
        step(1, 'hF000, 'hAB10, 0);
        chk(int'(trig_pulse), 1, "R7 zero delay fires on match");
        chk(int'(brk_req), 1, "R9 break enabled");
        chk(int'(cur_level), NL, "R7 level past last");
        step(0, 0, 0, 0);
        chk(int'(trig_pulse), 0, "R8 one-cycle pulse");
        chk(int'(triggered), 1, "R8 stays triggered");
        step(1, 'h100, 'h55, 2);
        chk(int'(cur_level), NL, "R8 no restart without arm");

        // Scenario B: one sample meets two levels.
        do_arm(0, 0, 0, 0);
        chk(int'(cur_level), 0, "R10 arm clears level");
        chk(int'(triggered), 0, "R10 arm clears triggered");
        step(1, 'h150, 'h55, 2);   chk(int'(cur_level), 1, "R6 single step per sample");
        step(1, 'h150, 'h55, 2);   chk(int'(cur_level), 2, "R6 next level on next sample");
        step(1, 'h150, 'h55, 2);   chk(int'(cur_level), 2, "R6 level 2 not met");

        // Scenario C: delay of 5 valid samples, break disabled.
        cfg_delay = 20'd5;
        cfg_break_en = 1'b0;
        do_arm(0, 0, 0, 0);
        pass_levels();
        chk(int'(cur_level), NL, "R7 counting level");
        chk(int'(trig_pulse), 0, "R7 no trigger at match with delay");
        step(1, 0, 0, 0); step(1, 0, 0, 0); step(0, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
        chk(int'(trig_pulse), 0, "R7 four valid samples not enough");
        step(1, 0, 0, 0);
        chk(int'(trig_pulse), 1, "R7 fires on fifth valid sample");
        chk(int'(brk_req), 0, "R9 break disabled");

        // Scenario D: arm collides with the firing sample.
        cfg_delay = 20'd2;
        cfg_break_en = 1'b1;
        do_arm(0, 0, 0, 0);
        pass_levels();
        step(1, 0, 0, 0);
        chk(int'(trig_pulse), 0, "R7 one of two samples");
        do_arm(1, 'h100, 'h55, 2);
        chk(int'(trig_pulse), 0, "R10 arm beats firing sample");
        chk(int'(brk_req), 0, "R10 no break on collision");
        chk(int'(cur_level), 0, "R10 arm beats level match");
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        chk(int'(trig_pulse), 0, "R10 counter cleared by arm");

        // Scenario E: op code 3 and the join bit.
        b_op[0] = 2'd3;
        step(1, 'h100, 'h55, 2);   chk(int'(cur_level), 0, "R3 op 3 never matches");
        b_and[0] = 1'b0;
        step(1, 'h100, 'h55, 2);   chk(int'(cur_level), 1, "R5 OR with address only");
        b_op[0] = 2'd0;
        b_and[0] = 1'b1;

        // Scenario F: long delay of 100000.
        cfg_delay = 20'd100000;
        do_arm(0, 0, 0, 0);
        pass_levels();
        for (int i = 0; i < 99999; i++) step(1, 0, 0, 0);
        chk(int'(trig_pulse), 0, "R7 long delay not yet");
        step(1, 0, 0, 0);
        chk(int'(trig_pulse), 1, "R7 long delay fires");
        chk(int'(brk_req), 1, "R9 break with long delay");
        step(0, 0, 0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule